// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Flags

This block is a single-clock FIFO with 18-bit write and read ports. A mode pin is captured while reset is held and picks one of two read behaviours. In standard mode, the read data register changes only on a clock edge where the read enable is high and the FIFO holds data. In fall-through mode, the oldest stored word moves into the read data register by itself. The read enable then retires that word and brings the next one forward.

Two pins change meaning with the mode. In standard mode they report empty and full. In fall-through mode they report that read data is valid and that a write can be accepted. A half-full flag and two programmable threshold flags report the fill level. The two thresholds are loaded through the write data bus: while the load pin is high, each write-enabled edge stores the data into the next threshold register, and no word enters the FIFO.

Top module: `dual_mode_fifo`

## Requirements
- R1: Reset empties the storage, clears the read data register to 0, and sets both threshold registers to 7. The mode pin is captured on every clock edge while reset is low: 0 selects standard mode and 1 selects fall-through mode.
- R2: On an edge with write enable high and load low, the write data is stored when the storage holds fewer than DEPTH words. When the storage is full, the write is dropped and the stored contents do not change.
- R3: In standard mode, the read data register takes the oldest stored word on an edge where read enable is high and the storage is not empty. Otherwise it holds its value, and a read of an empty FIFO changes nothing.
- R4: In fall-through mode, a word written into an empty FIFO is in storage after its write edge. It appears on the read data port, with the output-ready flag high, after the next edge, with no read enable needed.
- R5: In fall-through mode, read enable takes effect only while output-ready is high. It then either loads the next stored word or, if storage is empty, drops output-ready. With output-ready low, read enable has no effect.
- R6: In standard mode, out_flag is 1 when storage is empty and in_flag is 1 when storage holds DEPTH words. In fall-through mode, out_flag is 1 when the read data register holds a valid word and in_flag is 1 when storage holds fewer than DEPTH words, so DEPTH+1 words fit in total.
- R7: half_full is 1 when the fill level is greater than DEPTH/2. The fill level is the stored count, plus 1 for a valid read data register in fall-through mode.
- R8: almost_empty is 1 when the fill level is at or below the empty threshold. almost_full is 1 when DEPTH minus the stored count is at or below the full threshold.
- R9: While load is high, each write-enabled edge writes wr_data[CW-1:0] (CW = clog2(DEPTH+1)) into the empty threshold, then the full threshold, alternating. The sequence starts again at the empty threshold once load is low, and no FIFO write occurs while load is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low reset |
| fwft_sel | input | 1 | Mode select, captured during reset (1 = fall-through) |
| load | input | 1 | Routes write-enabled data into the threshold registers |
| wr_en | input | 1 | Write enable |
| wr_data | input | 18 | Write data |
| rd_en | input | 1 | Read enable |
| rd_data | output | 18 | Read data register |
| out_flag | output | 1 | Empty (standard mode) or output-ready (fall-through mode) |
| in_flag | output | 1 | Full (standard mode) or input-ready (fall-through mode) |
| half_full | output | 1 | Fill level above DEPTH/2 |
| almost_empty | output | 1 | Fill level at or below the empty threshold |
| almost_full | output | 1 | Free storage at or below the full threshold |

## Verification
A wrong stored count shows in the same cycle on out_flag, in_flag, half_full and the two threshold flags. All five are decoded from the registered count without any further register. A wrong pointer or a lost valid bit in the read data register shows as wrong read data on the first read that reaches the bad entry. In fall-through mode it can also show as output-ready low one edge after a write. A threshold register written out of order shows only when the fill level crosses that threshold, so the bench loads known values and then walks the fill level across them.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} rd_mode_e;
  typedef enum logic {SEL_LOW = 1'b0, SEL_HIGH = 1'b1} thr_sel_e;

  // Fill level seen by the flags: stored words plus a held output word.
  function automatic int unsigned fill_level(int unsigned stored, logic held, rd_mode_e m);
    return stored + ((m == MODE_FWFT && held) ? 1 : 0);
  endfunction

  function automatic int unsigned space_left(int unsigned stored, int unsigned depth);
    return depth - stored;
  endfunction

  function automatic logic over_half(int unsigned lvl, int unsigned depth);
    return lvl > (depth / 2);
  endfunction

  function automatic logic at_or_below(int unsigned lvl, int unsigned thr);
    return lvl <= thr;
  endfunction

  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/dmf_store.sv
module dmf_store #(
  parameter int W     = 18,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  import dmf_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= AW'(ptr_next(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(ptr_next(32'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/dmf_thresholds.sv
module dmf_thresholds #(
  parameter int CW      = 9,
  parameter int DEFAULT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          wr_en,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] low_thr,
  output logic [CW-1:0] high_thr
);
  import dmf_pkg::*;

  thr_sel_e sel;
  logic     ld_write;

  assign ld_write = load && wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_thr  <= CW'(DEFAULT);
      high_thr <= CW'(DEFAULT);
      sel      <= SEL_LOW;
    end else if (ld_write) begin
      if (sel == SEL_LOW) low_thr <= din;
      else                high_thr <= din;
      sel <= (sel == SEL_LOW) ? SEL_HIGH : SEL_LOW;
    end else if (!load) begin
      sel <= SEL_LOW;
    end
  end

  p_thr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_write |=> ($stable(low_thr) && $stable(high_thr)));
  p_one_thr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_write |=> ($stable(low_thr) || $stable(high_thr)));

endmodule

// File: rtl/dmf_outstage.sv
module dmf_outstage #(
  parameter int W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dmf_pkg::rd_mode_e mode,
  input  logic             rd_en,
  input  logic             avail,
  input  logic [W-1:0]     head,
  output logic [W-1:0]     rd_data,
  output logic             valid,
  output logic             take
);
  import dmf_pkg::*;

  always_comb begin
    if (mode == MODE_STD) take = rd_en && avail;
    else                  take = avail && (!valid || rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      valid   <= 1'b0;
    end else begin
      if (take) rd_data <= head;
      if (mode == MODE_FWFT) begin
        if (take)       valid <= 1'b1;
        else if (rd_en) valid <= 1'b0;
      end else begin
        valid <= 1'b0;
      end
    end
  end

  p_std_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STD && !rd_en) |=> $stable(rd_data));
  p_fwft_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FWFT && !valid && avail) |=> valid);
  p_fwft_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FWFT && !valid && !avail) |=> ($stable(rd_data) && !valid));

endmodule

// File: rtl/dmf_flags.sv
module dmf_flags #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  dmf_pkg::rd_mode_e mode,
  input  logic [CW-1:0]     count,
  input  logic              valid,
  input  logic [CW-1:0]     low_thr,
  input  logic [CW-1:0]     high_thr,
  output logic              out_flag,
  output logic              in_flag,
  output logic              half_full,
  output logic              almost_empty,
  output logic              almost_full
);
  import dmf_pkg::*;

  int unsigned lvl;
  int unsigned spc;
  logic        st_empty;
  logic        st_full;

  always_comb begin
    lvl          = fill_level(32'(count), valid, mode);
    spc          = space_left(32'(count), DEPTH);
    st_empty     = (count == '0);
    st_full      = (count == CW'(DEPTH));
    half_full    = over_half(lvl, DEPTH);
    almost_empty = at_or_below(lvl, 32'(low_thr));
    almost_full  = at_or_below(spc, 32'(high_thr));
    if (mode == MODE_STD) begin
      out_flag = st_empty;
      in_flag  = st_full;
    end else begin
      out_flag = valid;
      in_flag  = !st_full;
    end
  end

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int W       = 18,
  parameter int DEPTH   = 256,
  parameter int THR_RST = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fwft_sel,
  input  logic         load,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         out_flag,
  output logic         in_flag,
  output logic         half_full,
  output logic         almost_empty,
  output logic         almost_full
);
  import dmf_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  rd_mode_e      mode_q;
  logic [CW-1:0] fifo_count;
  logic [W-1:0]  head_word;
  logic          push_ok;
  logic          pop_take;
  logic          out_valid;
  logic [CW-1:0] low_thr, high_thr;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= fwft_sel ? MODE_FWFT : MODE_STD;
  end

  assign push_ok = wr_en && !load && (fifo_count < CW'(DEPTH));

  dmf_store #(.W(W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ok),
    .pop   (pop_take),
    .wdata (wr_data),
    .head  (head_word),
    .count (fifo_count)
  );

  dmf_outstage #(.W(W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .rd_en   (rd_en),
    .avail   (fifo_count != '0),
    .head    (head_word),
    .rd_data (rd_data),
    .valid   (out_valid),
    .take    (pop_take)
  );

  dmf_thresholds #(.CW(CW), .DEFAULT(THR_RST)) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .wr_en    (wr_en),
    .din      (wr_data[CW-1:0]),
    .low_thr  (low_thr),
    .high_thr (high_thr)
  );

  dmf_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .mode         (mode_q),
    .count        (fifo_count),
    .valid        (out_valid),
    .low_thr      (low_thr),
    .high_thr     (high_thr),
    .out_flag     (out_flag),
    .in_flag      (in_flag),
    .half_full    (half_full),
    .almost_empty (almost_empty),
    .almost_full  (almost_full)
  );

  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CW'(DEPTH) && !pop_take) |=> (fifo_count == CW'(DEPTH)));
  p_load_no_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !pop_take) |=> $stable(fifo_count));
  p_std_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STD && pop_take) |-> !out_flag);
  p_fwft_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FWFT && out_flag && !rd_en) |=> out_flag);
  p_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STD && half_full) |-> !out_flag);
  p_full_af_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CW'(DEPTH)) |-> almost_full);

endmodule

// File: tb/tb_dual_mode_fifo.sv
module tb_dual_mode_fifo;
  localparam int D = 16;
  localparam int W = 18;
  localparam int TW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwft_sel = 1'b0, load = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic out_flag, in_flag, half_full, almost_empty, almost_full;

  int total = 0;
  int bad = 0;

  int q[$];
  int m_out;
  bit m_valid, m_fw, m_sel;
  int m_lo, m_hi;

  dual_mode_fifo #(.W(W), .DEPTH(D), .THR_RST(7)) dut (
    .clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .load(load),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .out_flag(out_flag), .in_flag(in_flag), .half_full(half_full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  always #4 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit do_push, do_pop;
    if (!rst_n) begin
      q.delete();
      m_out = 0; m_valid = 0; m_fw = fwft_sel;
      m_lo = 7; m_hi = 7; m_sel = 0;
      return;
    end
    do_push = wr_en && !load && (q.size() < D);
    if (!m_fw) begin
      do_pop = rd_en && (q.size() > 0);
      if (do_pop) m_out = q.pop_front();
    end else begin
      do_pop = (q.size() > 0) && (!m_valid || rd_en);
      if (do_pop) begin
        m_out = q.pop_front();
        m_valid = 1;
      end else if (rd_en) m_valid = 0;
    end
    if (do_push) q.push_back(int'(wr_data));
    if (load && wr_en) begin
      if (!m_sel) m_lo = int'(wr_data) % (1 << TW);
      else        m_hi = int'(wr_data) % (1 << TW);
      m_sel = !m_sel;
    end else if (!load) m_sel = 0;
  endtask

  task automatic compare();
    int lvl;
    lvl = q.size() + ((m_fw && m_valid) ? 1 : 0);
    check(m_fw ? "R5" : "R3", "rd_data", int'(rd_data), m_out);
    check("R6", "out_flag", int'(out_flag), m_fw ? int'(m_valid) : int'(q.size() == 0));
    check("R6", "in_flag", int'(in_flag), m_fw ? int'(q.size() < D) : int'(q.size() == D));
    check("R7", "half_full", int'(half_full), int'(lvl * 2 > D));
    check("R8", "almost_empty", int'(almost_empty), int'(lvl <= m_lo));
    check("R8", "almost_full", int'(almost_full), int'((D - q.size()) <= m_hi));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(bit fw);
    fwft_sel = fw; rst_n = 1'b0;
    load = 0; wr_en = 0; rd_en = 0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  task automatic put(int d);
    wr_en = 1; wr_data = W'(d);
    step();
    wr_en = 0;
  endtask

  task automatic rand_run(int n);
    for (int i = 0; i < n; i++) begin
      int pw;
      pw = (i / 100 == 0) ? 70 : (i / 100 == 1) ? 30 : (i / 100 == 2) ? 50 : 90;
      wr_en = ($urandom % 100) < pw;
      rd_en = ($urandom % 100) < (100 - pw + 10);
      load = ($urandom % 40) == 0;
      wr_data = W'($urandom);
      step();
    end
    wr_en = 0; rd_en = 0; load = 0;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Standard mode
    do_reset(1'b0);
    check("R1", "rd_data after reset", int'(rd_data), 0);
    check("R1", "empty after reset", int'(out_flag), 1);
    check("R1", "almost_empty after reset", int'(almost_empty), 1);
    rd_en = 1; step(); rd_en = 0;
    check("R3", "read of empty ignored", int'(rd_data), 0);
    for (int i = 0; i < 20; i++) put(100 + i);
    check("R2", "full flag", int'(in_flag), 1);
    rd_en = 1;
    for (int i = 0; i < 16; i++) step();
    rd_en = 0;
    check("R2", "last kept word", int'(rd_data), 115);
    check("R2", "empty after 16 reads", int'(out_flag), 1);
    rd_en = 1; step(); rd_en = 0;
    check("R3", "hold on empty read", int'(rd_data), 115);
    // Default empty threshold 7: 7 words keep almost_empty, 8th clears it
    for (int i = 0; i < 7; i++) put(i);
    check("R1", "low threshold 7 at level 7", int'(almost_empty), 1);
    put(7);
    check("R1", "low threshold 7 at level 8", int'(almost_empty), 0);
    rd_en = 1; repeat (8) step(); rd_en = 0;
    // Threshold load: 3 -> low, 10 -> high, 5 -> low
    load = 1;
    put(3); put(10); put(5);
    load = 0;
    check("R9", "no FIFO write during load", int'(out_flag), 1);
    for (int i = 0; i < 5; i++) put(200 + i);
    check("R9", "low thr 5 at level 5", int'(almost_empty), 1);
    check("R9", "high thr 10 at free 11", int'(almost_full), 0);
    put(205);
    check("R9", "low thr 5 at level 6", int'(almost_empty), 0);
    check("R9", "high thr 10 at free 10", int'(almost_full), 1);
    rand_run(400);

    // Fall-through mode
    do_reset(1'b1);
    check("R1", "fwft not ready after reset", int'(out_flag), 0);
    check("R1", "fwft input ready after reset", int'(in_flag), 1);
    rd_en = 1; step(); rd_en = 0;
    check("R5", "read while not ready ignored", int'(out_flag), 0);
    put(18'h2AB);
    check("R4", "word still in storage", int'(out_flag), 0);
    step();
    check("R4", "word fell through", int'(rd_data), 18'h2AB);
    check("R4", "output ready", int'(out_flag), 1);
    put(1); put(2); put(3);
    rd_en = 1; step(); rd_en = 0;
    check("R5", "read advances", int'(rd_data), 1);
    for (int i = 0; i < 20; i++) put(300 + i);
    check("R6", "input not ready when full", int'(in_flag), 0);
    rd_en = 1; repeat (20) step(); rd_en = 0;
    check("R5", "ready drops when drained", int'(out_flag), 0);
    rand_run(400);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule